// File: doc/BRIEF.md
# Three-Operation Memory-to-Memory Processor

This block is a tiny processor core with almost no architectural state: a program counter and one flag bit. Code and data share a single external synchronous RAM, and every operand is a memory word. Each instruction word carries an opcode and two address fields. The core can add two words, NOR two words, or branch on the flag. Arithmetic and logic results always overwrite the word at the second address.

The core drives the RAM address, write data and write enable, and takes read data one cycle after it presents an address. A branch is taken only while the flag is clear, and every branch leaves the flag clear. An unconditional jump is therefore written as any operation that clears the flag, followed by a branch. A taken branch that targets its own address stops the core. This gives programs and test environments a clean end marker. The program counter, the flag and the stop indication are brought out for observation.

Top module: `tri_op_cpu`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the program counter is 0, the flag is 0, halted is 0 and no memory write occurs.
- R2: An add or NOR writes exactly one memory word, at the second address field, for exactly one cycle. No other word changes.
- R3: Instruction word layout: bits [15:14] are the opcode (00 branch, 01 add, 10 NOR, 11 no-operation), bits [13:7] are the first address and bits [6:0] are the second. A branch executed with the flag at 0 loads the first address field into the program counter.
- R4: A branch executed with the flag at 1 advances the program counter by one. Every branch, taken or not, leaves the flag at 0.
- R5: Add writes the 16-bit sum of the words at the two addresses to the second address. The carry out of bit 15 goes into the flag, and the program counter advances by one.
- R6: NOR writes the bitwise NOR of the two words to the second address. The flag becomes 1 if the result is zero and 0 otherwise, and the program counter advances by one.
- R7: Opcode 11 writes no memory, leaves the flag unchanged and advances the program counter by one.
- R8: A taken branch whose target equals its own address raises halted. From then on the program counter holds, the flag holds and no write occurs until reset.
- R9: When both address fields are equal, both operands are the word's value before the instruction, so add doubles the word and NOR complements it.
- R10: Counted in clock cycles from the release of reset, a branch or a no-operation takes 2 cycles and an add or NOR takes 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 7 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | 16 | RAM read data, valid one cycle after the address |
| pc_o | output | 7 | Current program counter |
| flag_o | output | 1 | Current flag |
| halted_o | output | 1 | Self-branch stop indication |

## Verification
The assertions take for granted a RAM that returns the addressed word exactly one cycle after the core presents the address, and a reset held for at least one edge before the first instruction. The stimulus keeps operand addresses in a data region separate from the code, so no program rewrites itself. Branch targets in random programs point only forward, so every program reaches its final self-branch. That self-branch is preceded by an add of a reserved zero word to itself, which clears the flag, so each run ends in a halt whose cycle count and memory image a reference model in the bench predicts.

// File: rtl/tri_op_cpu.sv
module tri_op_cpu #(
  parameter int ADDR_W = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [2*ADDR_W+1:0]     mem_wdata,
  output logic                    mem_we,
  input  logic [2*ADDR_W+1:0]     mem_rdata,
  output logic [ADDR_W-1:0]       pc_o,
  output logic                    flag_o,
  output logic                    halted_o
);
  localparam int DW = 2*ADDR_W + 2;
  localparam logic [1:0] OP_BR  = 2'b00;
  localparam logic [1:0] OP_ADD = 2'b01;
  localparam logic [1:0] OP_NOR = 2'b10;
  localparam logic [1:0] OP_NOP = 2'b11;

  typedef enum logic [2:0] {
    S_FETCH, S_DEC, S_OPA, S_OPB, S_WB, S_INC, S_HALT
  } state_t;

  state_t            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic              f_q;
  logic              halt_q;
  logic [DW-1:0]     ir_q;
  logic [DW-1:0]     opa_q, opb_q;
  logic [DW-1:0]     result;
  logic              new_flag;

  wire [1:0]        rd_op = mem_rdata[DW-1 -: 2];
  wire [ADDR_W-1:0] rd_a1 = mem_rdata[2*ADDR_W-1 -: ADDR_W];
  wire [1:0]        ir_op = ir_q[DW-1 -: 2];
  wire [ADDR_W-1:0] ir_a2 = ir_q[ADDR_W-1:0];

  always_comb begin
    result   = '0;
    new_flag = 1'b0;
    if (ir_op == OP_ADD) begin
      {new_flag, result} = {1'b0, opa_q} + {1'b0, opb_q};
    end else begin
      result   = ~(opa_q | opb_q);
      new_flag = (result == '0);
    end
  end

  always_comb begin
    case (state_q)
      S_DEC:        mem_addr = rd_a1;
      S_OPA, S_OPB,
      S_WB:         mem_addr = ir_a2;
      default:      mem_addr = pc_q;
    endcase
  end

  assign mem_we    = (state_q == S_WB);
  assign mem_wdata = result;
  assign pc_o      = pc_q;
  assign flag_o    = f_q;
  assign halted_o  = halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH;
      pc_q    <= '0;
      f_q     <= 1'b0;
      halt_q  <= 1'b0;
      ir_q    <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
    end else begin
      case (state_q)
        S_FETCH: state_q <= S_DEC;
        S_DEC: begin
          ir_q <= mem_rdata;
          case (rd_op)
            OP_BR: begin
              f_q     <= 1'b0;
              state_q <= S_FETCH;
              if (!f_q) begin
                pc_q <= rd_a1;
                if (rd_a1 == pc_q) begin
                  halt_q  <= 1'b1;
                  state_q <= S_HALT;
                end
              end else begin
                pc_q <= pc_q + 1'b1;
              end
            end
            OP_NOP: begin
              pc_q    <= pc_q + 1'b1;
              state_q <= S_FETCH;
            end
            default: state_q <= S_OPA;
          endcase
        end
        S_OPA: begin
          opa_q   <= mem_rdata;
          state_q <= S_OPB;
        end
        S_OPB: begin
          opb_q   <= mem_rdata;
          state_q <= S_WB;
        end
        S_WB: begin
          f_q     <= new_flag;
          state_q <= S_INC;
        end
        S_INC: begin
          pc_q    <= pc_q + 1'b1;
          state_q <= S_FETCH;
        end
        default: state_q <= S_HALT;
      endcase
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && !f_q && !halt_q && !mem_we));

  // R2
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R4
  br_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DEC && rd_op == OP_BR) |=> !f_q);

  // R7
  nop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DEC && rd_op == OP_NOP) |=>
      (f_q == $past(f_q) && pc_q == $past(pc_q) + 1'b1 && !mem_we));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> (halt_q && $stable(pc_q) && $stable(f_q) && !mem_we));
endmodule

// File: tb/tri_op_cpu_bench.sv
`timescale 1ns/1ps
module tri_op_cpu_bench;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic mem_we;
  logic [AW-1:0] pc_o;
  logic flag_o, halted_o;

  logic [DW-1:0] ram [NW];
  logic [DW-1:0] img [NW];
  logic [DW-1:0] gold [NW];
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;

  int n_chk = 0, n_fail = 0;
  int g_pc, g_cyc;
  bit g_f, g_halt;

  always #4 clk = ~clk;

  tri_op_cpu #(.ADDR_W(AW)) u_tri_op_cpu (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .pc_o(pc_o),
    .flag_o(flag_o), .halted_o(halted_o));

  always @(posedge clk) begin
    if (ld_en) ram[ld_addr] <= ld_data;
    else if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  int we_after_halt = 0;
  always @(posedge clk) if (halted_o && mem_we) we_after_halt++;

  function automatic logic [DW-1:0] ins(input int op, input int a1, input int a2);
    return {op[1:0], a1[AW-1:0], a2[AW-1:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic iss();
    int pc = 0, steps = 0;
    bit f = 0, h = 0;
    logic [DW-1:0] w, s;
    logic [DW:0] sum;
    int a1, a2;
    for (int i = 0; i < NW; i++) gold[i] = img[i];
    g_cyc = 0;
    while (!h && steps < 4000) begin
      w = gold[pc]; a1 = w[13:7]; a2 = w[6:0];
      steps++;
      case (w[15:14])
        2'b00: begin
          g_cyc += 2;
          if (!f) begin
            if (a1 == pc) h = 1;
            pc = a1;
          end else pc = (pc + 1) % NW;
          f = 0;
        end
        2'b01: begin
          g_cyc += 6;
          sum = {1'b0, gold[a1]} + {1'b0, gold[a2]};
          gold[a2] = sum[DW-1:0]; f = sum[DW];
          pc = (pc + 1) % NW;
        end
        2'b10: begin
          g_cyc += 6;
          s = ~(gold[a1] | gold[a2]);
          gold[a2] = s; f = (s == '0);
          pc = (pc + 1) % NW;
        end
        default: begin
          g_cyc += 2;
          pc = (pc + 1) % NW;
        end
      endcase
    end
    g_pc = pc; g_f = f; g_halt = h;
  endtask

  task automatic load_and_reset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < NW; i++) begin
      ld_en = 1'b1; ld_addr = i[AW-1:0]; ld_data = img[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input string tag, output int cyc);
    int lim;
    load_and_reset();
    // R1: state held in reset
    chk(pc_o == 0 && !flag_o && !halted_o && !mem_we, {tag, " R1 reset"},
        {pc_o, flag_o, halted_o, mem_we}, 0);
    rst = 1'b0;
    cyc = 0; lim = 20000;
    while (!halted_o && cyc < lim) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    if (cyc >= lim) chk(0, {tag, " R8 watchdog"}, cyc, lim);
  endtask

  task automatic compare(input string tag, input int cyc);
    int bad = -1;
    iss();
    chk(halted_o == g_halt, {tag, " R8 halted"}, halted_o, g_halt);
    chk(pc_o == g_pc[AW-1:0], {tag, " R3 R4 pc"}, pc_o, g_pc);
    chk(flag_o == g_f, {tag, " R4 flag"}, flag_o, g_f);
    chk(cyc == g_cyc, {tag, " R10 cycles"}, cyc, g_cyc);
    for (int i = NW - 1; i >= 0; i--) if (ram[i] !== gold[i]) bad = i;
    chk(bad < 0, {tag, " R2 R5 R6 memory image"}, bad < 0 ? 0 : ram[bad],
        bad < 0 ? 0 : gold[bad]);
  endtask

  task automatic clear_img();
    for (int i = 0; i < NW; i++) img[i] = '0;
  endtask

  initial begin
    int cyc;
    void'($urandom(32'h5a17));

    // R5: add with carry, flag set makes following branch fall through
    clear_img();
    img[64] = 16'hFFFF; img[65] = 16'h0002;
    img[0] = ins(1, 64, 65); img[1] = ins(0, 3, 0);
    img[2] = ins(0, 2, 0);   img[3] = ins(0, 3, 0);
    run("add", cyc);
    chk(ram[65] == 16'h0001, "R5 sum word", ram[65], 16'h0001);
    chk(pc_o == 2, "R4 fall-through after carry", pc_o, 2);
    chk(cyc == 10, "R10 add path cycles", cyc, 10);
    chk(ram[64] == 16'hFFFF, "R2 first operand untouched", ram[64], 16'hFFFF);
    compare("add", cyc);

    // R6: NOR giving zero sets flag
    clear_img();
    img[66] = 16'h00F0; img[67] = 16'hFF0F;
    img[0] = ins(2, 66, 67); img[1] = ins(0, 3, 0);
    img[2] = ins(0, 2, 0);   img[3] = ins(0, 3, 0);
    run("nor0", cyc);
    chk(ram[67] == 16'h0000, "R6 zero result", ram[67], 0);
    chk(pc_o == 2, "R6 flag set on zero", pc_o, 2);
    compare("nor0", cyc);

    // R6: NOR non-zero clears flag, branch taken
    clear_img();
    img[68] = 16'h1234; img[69] = 16'h0001;
    img[0] = ins(2, 68, 69); img[1] = ins(0, 3, 0);
    img[2] = ins(0, 2, 0);   img[3] = ins(0, 3, 0);
    run("nor1", cyc);
    chk(ram[69] == 16'hEDCA, "R6 nonzero result", ram[69], 16'hEDCA);
    chk(pc_o == 3, "R3 taken after clear flag", pc_o, 3);
    compare("nor1", cyc);

    // R3: plain jump with clear flag, R8 self-branch
    clear_img();
    img[0] = ins(0, 5, 9); img[5] = ins(0, 5, 0);
    run("jump", cyc);
    chk(pc_o == 5 && halted_o, "R3 R8 jump then halt", pc_o, 5);
    chk(cyc == 4, "R10 branch cycles", cyc, 4);
    compare("jump", cyc);

    // R7: no-op keeps flag and memory
    clear_img();
    img[64] = 16'hFFFF; img[65] = 16'h0001; img[66] = 16'hBEEF;
    img[0] = ins(1, 64, 65); img[1] = ins(3, 64, 66);
    img[2] = ins(0, 4, 0);   img[3] = ins(0, 3, 0); img[4] = ins(0, 4, 0);
    run("nop", cyc);
    chk(pc_o == 3, "R7 flag kept across no-op", pc_o, 3);
    chk(ram[66] == 16'hBEEF, "R7 no write", ram[66], 16'hBEEF);
    chk(cyc == 12, "R10 no-op cycles", cyc, 12);
    compare("nop", cyc);

    // R9: same address for both operands
    clear_img();
    img[70] = 16'h4001; img[71] = 16'h00FF;
    img[0] = ins(1, 70, 70); img[1] = ins(2, 71, 71); img[2] = ins(0, 2, 0);
    run("alias", cyc);
    chk(ram[70] == 16'h8002, "R9 add doubles", ram[70], 16'h8002);
    chk(ram[71] == 16'hFF00, "R9 nor complements", ram[71], 16'hFF00);
    compare("alias", cyc);

    // R8: hold after halt
    we_after_halt = 0;
    repeat (20) @(negedge clk);
    chk(pc_o == 2 && halted_o, "R8 pc held", pc_o, 2);
    chk(we_after_halt == 0, "R8 no write after halt", we_after_halt, 0);

    // random programs with forward branches
    for (int p = 0; p < 24; p++) begin
      int k, op, t;
      clear_img();
      k = 8 + $urandom % 24;
      for (int i = 64; i < 120; i++) img[i] = $urandom;
      if (p % 3 == 0) for (int i = 64; i < 72; i++) img[i] = 16'hFFFF;
      for (int i = 0; i < k - 2; i++) begin
        op = $urandom % 4;
        if (op == 0) begin
          t = i + 1 + ($urandom % (k - 1 - i));
          img[i] = ins(0, t, 0);
        end else begin
          img[i] = ins(op, 64 + $urandom % 56, 64 + $urandom % 56);
        end
      end
      img[k-2] = ins(1, 127, 127);
      img[k-1] = ins(0, k - 1, 0);
      run($sformatf("rand%0d", p), cyc);
      compare($sformatf("rand%0d R5 R6", p), cyc);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule